// File: doc/BRIEF.md
# Reuse-Filtered Two-Level Tag Controller

This block tracks which memory blocks are resident in a two-level cache arrangement. A small fully associative filter buffer sits in front of a larger direct-mapped main cache. A block seen for the first time lands only in the filter. It earns a place in the main cache only when it shows reuse, so lightly used blocks are kept out of the main array. Only tags and state are handled here. Data storage, the backing memory and writes are handled elsewhere.

Two promotion policies can be selected. In reuse mode, any filter hit promotes the block. In sampling mode, a filter hit promotes only when a free-running LFSR sample selects it. The selection probability is 2^-k for a programmable k, and no per-block counters are kept. A promoted block leaves the filter and takes its direct-mapped slot, displacing whatever was there. Both structures are searched in the same cycle for every request.

Requests arrive on a valid/ready channel. Each accepted request produces one registered response on a second valid/ready channel. The response holds exactly one of filter hit, main hit or miss, plus promotion and eviction flags. Back-pressure on the response stalls the request side: `req_ready` is high when no response is pending, or when the pending one is being taken in the same cycle. A pending response stays unchanged until it is taken.

Top module: `dual_tag_filter`

## Requirements
- R1: After reset, `rsp_valid` is 0, `req_ready` is 1 and both structures are empty, so the first request is a miss.
- R2: A request that misses in both structures is reported as a miss. Its block is placed only in the filter, so the next request to that block is a filter hit and not a main hit.
- R3: With `mode_sample`=0, a filter hit is reported with `rsp_promote`=1, and the following request to that block is a main hit.
- R4: Promotion removes the block from the filter. A block is never found in both structures at once. Once a promoted block is displaced from the main cache, its next request is a miss.
- R5: The main cache slot is given by request address bits [9:6], with 16 slots at the defaults. Promotion into an occupied slot is reported with `rsp_evict`=1. Promotion into an empty slot is reported with `rsp_evict`=0.
- R6: The filter holds 4 blocks. A miss fills an empty entry if one exists. Otherwise it replaces the least recently inserted or hit entry.
- R7: With `mode_sample`=1, a filter hit promotes only when the top `sample_k` bits of a 16-bit LFSR are all zero. A `sample_k` of 0 always promotes. The LFSR resets to 0xACE1 and shifts left once per accepted request, inserting XOR of bits 15, 13, 12 and 10 at bit 0. The sample uses the value before the shift.
- R8: In sampling mode, a filter hit that is not selected leaves the block in the filter and marks it most recently used.
- R9: Each response has exactly one of `rsp_filt_hit`, `rsp_main_hit` and `rsp_miss` set. `rsp_promote` appears only with a filter hit, and `rsp_evict` appears only with a promotion.
- R10: While `rsp_valid`=1 and `rsp_ready`=0, the response fields hold and `req_ready` is 0. A request offered at that time is not accepted.
- R11: Blocks are 64 bytes. Addresses that differ only in bits [5:0] refer to the same block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sample | input | 1 | 0 = reuse promotion, 1 = sampled promotion |
| sample_k | input | 4 | Number of top LFSR bits that must be zero to select |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_addr | input | 32 | Byte address of the request |
| rsp_valid | output | 1 | Response pending |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_filt_hit | output | 1 | Block was found in the filter |
| rsp_main_hit | output | 1 | Block was found in the main cache |
| rsp_miss | output | 1 | Block was found in neither structure |
| rsp_promote | output | 1 | Block moved from the filter into the main cache |
| rsp_evict | output | 1 | Promotion displaced a main cache line |

## Verification
Some properties are checked by assertions on every cycle. These are the one-hot response classification and the flag implications, the hold of a stalled response, that no block is present in both structures, that at most one filter entry matches, and that the LFSR never locks at zero. Other behaviour can only be shown by the directed scenarios, because it depends on request order. This covers filter-only insertion, promotion on reuse, displacement and re-miss of a promoted block, LRU victim choice with recency refresh, and promotion decisions checked against an independent LFSR model for several values of k.

// File: rtl/dtf_pkg.sv
package dtf_pkg;
  typedef enum logic {
    MODE_REUSE  = 1'b0,
    MODE_SAMPLE = 1'b1
  } dtf_mode_e;

  typedef struct packed {
    logic filt_hit;
    logic main_hit;
    logic miss;
    logic promote;
    logic evict;
  } dtf_rsp_t;
endpackage

// File: rtl/dtf_sampler.sv
module dtf_sampler #(
  parameter int          W    = 16,
  parameter int          K_W  = 4,
  parameter logic [W-1:0] SEED = 16'hACE1,
  parameter logic [W-1:0] TAPS = 16'hB400
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           adv,
  input  logic [K_W-1:0] k,
  output logic           sel
);
  logic [W-1:0] lfsr_q;
  logic [W-1:0] topbits;
  logic         fb;

  assign fb      = ^(lfsr_q & TAPS);
  assign topbits = lfsr_q >> (W - int'(k));
  assign sel     = (topbits == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)   lfsr_q <= SEED;
    else if (adv) lfsr_q <= {lfsr_q[W-2:0], fb};
  end

  // LFSR must never reach the all-zero lock state
  assert_lfsr_live_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lfsr_q != '0);
endmodule

// File: rtl/dtf_filter.sv
module dtf_filter #(
  parameter int BLK_W = 26,
  parameter int N     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BLK_W-1:0] look_blk,
  output logic             hit,
  input  logic             touch_en,
  input  logic             ins_en,
  input  logic             inv_en
);
  localparam int IW = $clog2(N);

  logic [BLK_W-1:0] tag_q [N];
  logic [IW-1:0]    age_q [N];
  logic [N-1:0]     vld_q;
  logic [N-1:0]     hit_vec;
  logic [IW-1:0]    hit_idx, victim, tgt;
  logic             found;
  logic             do_touch;

  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign hit_vec[i] = vld_q[i] && (tag_q[i] == look_blk);
  end

  assign hit = |hit_vec;

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < N; i++)
      if (hit_vec[i]) hit_idx = IW'(i);
  end

  always_comb begin
    victim = '0;
    found  = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (!vld_q[i] && !found) begin
        victim = IW'(i);
        found  = 1'b1;
      end
    end
    if (!found) begin
      for (int i = 0; i < N; i++)
        if (age_q[i] == IW'(N - 1)) victim = IW'(i);
    end
  end

  assign tgt      = ins_en ? victim : hit_idx;
  assign do_touch = ins_en || touch_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int i = 0; i < N; i++) begin
        age_q[i] <= IW'(i);
        tag_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < N; i++) begin
        if (do_touch) begin
          if (IW'(i) == tgt)              age_q[i] <= '0;
          else if (age_q[i] < age_q[tgt]) age_q[i] <= age_q[i] + 1'b1;
        end
        if (ins_en && IW'(i) == victim) begin
          vld_q[i] <= 1'b1;
          tag_q[i] <= look_blk;
        end
        if (inv_en && IW'(i) == hit_idx) vld_q[i] <= 1'b0;
      end
    end
  end

  // a block occupies at most one filter entry
  assert_single_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));
  // insertion only happens for a block not already held
  assert_insert_on_absent_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ins_en |-> !hit);
endmodule

// File: rtl/dtf_main.sv
module dtf_main #(
  parameter int IDX_W = 4,
  parameter int TAG_W = 22
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] idx,
  input  logic [TAG_W-1:0] tag,
  input  logic             wr_en,
  output logic             hit,
  output logic             occupied
);
  localparam int SLOTS = 1 << IDX_W;

  logic [TAG_W-1:0] tag_q [SLOTS];
  logic [SLOTS-1:0] vld_q;

  assign occupied = vld_q[idx];
  assign hit      = occupied && (tag_q[idx] == tag);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= '0;
      for (int i = 0; i < SLOTS; i++) tag_q[i] <= '0;
    end else if (wr_en) begin
      vld_q[idx] <= 1'b1;
      tag_q[idx] <= tag;
    end
  end
endmodule

// File: rtl/dual_tag_filter.sv
module dual_tag_filter #(
  parameter int ADDR_W   = 32,
  parameter int OFFSET_W = 6,
  parameter int IDX_W    = 4,
  parameter int FILT_N   = 4,
  parameter int LFSR_W   = 16,
  parameter int K_W      = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_sample,
  input  logic [K_W-1:0]    sample_k,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_filt_hit,
  output logic              rsp_main_hit,
  output logic              rsp_miss,
  output logic              rsp_promote,
  output logic              rsp_evict
);
  import dtf_pkg::*;

  localparam int BLK_W = ADDR_W - OFFSET_W;
  localparam int TAG_W = BLK_W - IDX_W;

  logic [BLK_W-1:0] blk;
  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] mtag;
  logic             fire, f_hit, m_hit, m_occ, sel, promote;
  dtf_mode_e        mode;
  dtf_rsp_t         rsp_q, rsp_d;

  assign mode      = dtf_mode_e'(mode_sample);
  assign req_ready = !rsp_valid || rsp_ready;
  assign fire      = req_valid && req_ready;
  assign blk       = req_addr[ADDR_W-1:OFFSET_W];
  assign idx       = blk[IDX_W-1:0];
  assign mtag      = blk[BLK_W-1:IDX_W];
  assign promote   = fire && f_hit && (mode == MODE_REUSE || sel);

  dtf_filter #(.BLK_W(BLK_W), .N(FILT_N)) u_filter (
    .clk      (clk),
    .rst_n    (rst_n),
    .look_blk (blk),
    .hit      (f_hit),
    .touch_en (fire && f_hit && !promote),
    .ins_en   (fire && !f_hit && !m_hit),
    .inv_en   (promote)
  );

  dtf_main #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_main (
    .clk      (clk),
    .rst_n    (rst_n),
    .idx      (idx),
    .tag      (mtag),
    .wr_en    (promote),
    .hit      (m_hit),
    .occupied (m_occ)
  );

  dtf_sampler #(.W(LFSR_W), .K_W(K_W)) u_sampler (
    .clk   (clk),
    .rst_n (rst_n),
    .adv   (fire),
    .k     (sample_k),
    .sel   (sel)
  );

  always_comb begin
    rsp_d.filt_hit = f_hit;
    rsp_d.main_hit = m_hit && !f_hit;
    rsp_d.miss     = !f_hit && !m_hit;
    rsp_d.promote  = promote;
    rsp_d.evict    = promote && m_occ;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_q     <= '0;
    end else if (fire) begin
      rsp_valid <= 1'b1;
      rsp_q     <= rsp_d;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  assign rsp_filt_hit = rsp_q.filt_hit;
  assign rsp_main_hit = rsp_q.main_hit;
  assign rsp_miss     = rsp_q.miss;
  assign rsp_promote  = rsp_q.promote;
  assign rsp_evict    = rsp_q.evict;

  assert_one_class_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $countones({rsp_filt_hit, rsp_main_hit, rsp_miss}) == 1);
  assert_promote_needs_fhit_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_promote) |-> rsp_filt_hit);
  assert_evict_needs_promote_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_evict) |-> rsp_promote);
  assert_stall_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_q)));
  assert_never_both_R4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> !(f_hit && m_hit));
endmodule

// File: tb/test_dual_tag_filter.sv
`timescale 1ns/1ps
module test_dual_tag_filter;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        mode_sample = 0;
  logic [3:0]  sample_k = 0;
  logic        req_valid = 0;
  logic        req_ready;
  logic [31:0] req_addr = 0;
  logic        rsp_valid;
  logic        rsp_ready = 1;
  logic        rsp_filt_hit, rsp_main_hit, rsp_miss, rsp_promote, rsp_evict;

  int errs = 0;
  int checks = 0;
  logic [15:0] lfsr_m;
  logic        exp_sel;

  localparam logic [4:0] MISS  = 5'b00100;
  localparam logic [4:0] FHIT  = 5'b10000;
  localparam logic [4:0] FPROM = 5'b10010;
  localparam logic [4:0] FPEV  = 5'b10011;
  localparam logic [4:0] MHIT  = 5'b01000;

  always #2.5 clk = ~clk;

  dual_tag_filter i_dual_tag_filter (
    .clk(clk), .rst_n(rst_n), .mode_sample(mode_sample), .sample_k(sample_k),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_filt_hit(rsp_filt_hit), .rsp_main_hit(rsp_main_hit), .rsp_miss(rsp_miss),
    .rsp_promote(rsp_promote), .rsp_evict(rsp_evict)
  );

  function automatic logic [31:0] mk(input int tag, input int idx, input int off);
    return (32'(tag) << 10) | (32'(idx & 15) << 6) | 32'(off & 63);
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic lfsr_step();
    lfsr_m = {lfsr_m[14:0], lfsr_m[15] ^ lfsr_m[13] ^ lfsr_m[12] ^ lfsr_m[10]};
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; req_valid = 0; rsp_ready = 1;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1;
    lfsr_m = 16'hACE1;
  endtask

  // one accepted request; returns the response flags
  task automatic req(input logic [31:0] a, output logic [4:0] r);
    exp_sel = (sample_k == 0) || ((lfsr_m >> (16 - int'(sample_k))) == 0);
    req_valid = 1; req_addr = a;
    @(posedge clk);
    lfsr_step();
    @(negedge clk);
    req_valid = 0;
    r = {rsp_filt_hit, rsp_main_hit, rsp_miss, rsp_promote, rsp_evict};
    checks++;
    if (rsp_valid !== 1'b1) begin
      errs++;
      $display("FAIL R9 response missing actual=%b expected=1", rsp_valid);
    end
  endtask

  task automatic t_reset();
    logic [4:0] r;
    do_reset();
    mode_sample = 0;
    chk("R1 rsp_valid", {7'd0, rsp_valid}, 8'd0);
    chk("R1 req_ready", {7'd0, req_ready}, 8'd1);
    req(mk(3, 2, 0), r);
    chk("R1 first miss", {3'd0, r}, {3'd0, MISS});
  endtask

  task automatic t_reuse();
    logic [4:0] r;
    do_reset();
    mode_sample = 0;
    req(mk(5, 1, 4), r);   chk("R2 miss", {3'd0, r}, {3'd0, MISS});
    req(mk(5, 1, 63), r);  chk("R3 R11 filter hit promotes", {3'd0, r}, {3'd0, FPROM});
    req(mk(5, 1, 0), r);   chk("R3 main hit", {3'd0, r}, {3'd0, MHIT});
  endtask

  task automatic t_conflict();
    logic [4:0] r;
    do_reset();
    mode_sample = 0;
    req(mk(7, 9, 0), r);
    req(mk(7, 9, 0), r);   chk("R5 empty slot no evict", {3'd0, r}, {3'd0, FPROM});
    req(mk(8, 9, 0), r);   chk("R2 conflict miss", {3'd0, r}, {3'd0, MISS});
    req(mk(8, 9, 8), r);   chk("R5 displacing promote", {3'd0, r}, {3'd0, FPEV});
    req(mk(7, 9, 0), r);   chk("R4 displaced re-miss", {3'd0, r}, {3'd0, MISS});
    req(mk(8, 9, 0), r);   chk("R5 new owner hits", {3'd0, r}, {3'd0, MHIT});
  endtask

  task automatic t_lru();
    logic [4:0] r;
    do_reset();
    mode_sample = 1; sample_k = 4'd15;
    for (int i = 0; i < 4; i++) begin
      req(mk(20 + i, i, 0), r);
      chk("R6 fill miss", {3'd0, r}, {3'd0, MISS});
    end
    req(mk(20, 0, 0), r);
    chk("R8 unselected hit", {3'd0, r}, {3'd0, exp_sel ? FPROM : FHIT});
    req(mk(24, 4, 0), r);  chk("R6 full miss", {3'd0, r}, {3'd0, MISS});
    req(mk(20, 0, 0), r);
    chk("R6 R8 refreshed entry kept", {3'd0, r}, {3'd0, exp_sel ? FPROM : FHIT});
    req(mk(21, 1, 0), r);  chk("R6 LRU victim gone", {3'd0, r}, {3'd0, MISS});
    req(mk(23, 3, 0), r);
    chk("R6 younger entry kept", {3'd0, r}, {3'd0, exp_sel ? FPROM : FHIT});
  endtask

  task automatic t_sample_all();
    logic [4:0] r;
    do_reset();
    mode_sample = 1; sample_k = 4'd0;
    req(mk(11, 6, 0), r);  chk("R2 miss", {3'd0, r}, {3'd0, MISS});
    req(mk(11, 6, 0), r);  chk("R7 k=0 promotes", {3'd0, r}, {3'd0, FPROM});
    req(mk(11, 6, 0), r);  chk("R7 main hit after", {3'd0, r}, {3'd0, MHIT});
  endtask

  task automatic t_sample_prob(input logic [3:0] k);
    logic [4:0] r, e;
    int st, blkn, nprom, nskip;
    do_reset();
    mode_sample = 1; sample_k = k;
    st = 0; blkn = 0; nprom = 0; nskip = 0;
    for (int n = 0; n < 60; n++) begin
      req(mk(blkn + 1, blkn, 0), r);
      if (st == 0) begin
        e = MISS; st = 1;
      end else if (st == 1) begin
        if (exp_sel) begin
          e = (blkn >= 16) ? FPEV : FPROM; st = 2; nprom++;
        end else begin
          e = FHIT; nskip++;
        end
      end else begin
        e = MHIT; st = 0; blkn++;
      end
      chk("R7 sampled promotion", {3'd0, r}, {3'd0, e});
    end
    chk("R7 some promoted", {7'd0, nprom > 0}, 8'd1);
    chk("R8 some not selected", {7'd0, nskip > 0}, 8'd1);
  endtask

  task automatic t_backpressure();
    logic [4:0] r;
    do_reset();
    mode_sample = 0;
    rsp_ready = 0;
    req_valid = 1; req_addr = mk(2, 5, 0);
    @(posedge clk); lfsr_step();
    @(negedge clk);
    chk("R10 pending valid", {7'd0, rsp_valid}, 8'd1);
    chk("R10 req_ready low", {7'd0, req_ready}, 8'd0);
    req_addr = mk(2, 5, 0);   // second request offered while stalled
    @(posedge clk); @(negedge clk);
    @(posedge clk); @(negedge clk);
    r = {rsp_filt_hit, rsp_main_hit, rsp_miss, rsp_promote, rsp_evict};
    chk("R10 held response", {3'd0, r}, {3'd0, MISS});
    chk("R10 still stalled", {7'd0, req_ready}, 8'd0);
    rsp_ready = 1;
    @(posedge clk); lfsr_step();
    @(negedge clk);
    req_valid = 0;
    r = {rsp_filt_hit, rsp_main_hit, rsp_miss, rsp_promote, rsp_evict};
    chk("R10 accepted once released", {3'd0, r}, {3'd0, FPROM});
    @(negedge clk);
    chk("R10 drained", {7'd0, rsp_valid}, 8'd0);
  endtask

  initial begin
    #100000;
    errs++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    lfsr_m = 16'hACE1;
    t_reset();
    t_reuse();
    t_conflict();
    t_lru();
    t_sample_all();
    t_sample_prob(4'd2);
    t_sample_prob(4'd1);
    t_backpressure();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule